// File: doc/BRIEF.md
# Board Configuration Register Block

This block is a 32-bit register bank on a simple single-cycle memory-mapped bus. It has a 4 KB window. It holds two general configuration words and a loop-lock status word, and it contains a small configuration channel. Bit 0 of the first configuration word drives a remap line. The low bits of the second configuration word drive a bank of LED outputs. The lock status word reports per-loop lock flags and gives one summary bit, filtered by a mask that software can write.

The configuration channel gives software indirect access to a parameterised array of oscillator-clock setting words. Software first loads an outgoing data word. It then writes a command word that holds a function code, a device number, a direction bit and a start bit. The transfer completes on that same clock edge. A status word then reports completion and whether the request was rejected. Read transfers put the selected setting into a return data register. Two read-only identity words come from parameters. A switch word always reads as zero.

Reads are combinational from the word address. Writes take effect on the rising clock edge on which `wr_en` is high.

Top module: `board_cfg_ctrl`

## Requirements
- R1: The command word at offset 0xA8 is laid out as follows: device number in bits [11:0], function code in bits [25:20], direction in bit 30 (1 = write, 0 = read) and start in bit 31. Bits [19:12] and [29:26] are reserved.
- R2: A write to the command word stores every bit except the start bit and the reserved bits, which always read back as zero. Writing 0xFFFF_FFFF reads back as 0x43F0_0FFF.
- R3: Every write to the command word clears the status word at offset 0xAC (DONE in bit 0, ERROR in bit 1). A write with start clear therefore leaves status at 0.
- R4: A command write with start set completes at that clock edge, and status bit 0 (DONE) reads 1 immediately afterwards.
- R5: A request is rejected when the function code is not 1, or when the full 12-bit device number is not below NUM_OSC. A rejected request sets status to 0x3 and changes neither the setting array nor the return data word.
- R6: An accepted write request copies the outgoing data word (offset 0xA4, read/write) into the selected setting entry, and status reads 0x1.
- R7: An accepted read request loads the selected setting entry into the return data word (offset 0xA0), and status reads 0x1.
- R8: Reset is synchronous and active high. After reset the command word reads 0x0010_0000 and status reads 0. Each setting entry i holds OSC_RESET[i]. Configuration word 0 (offset 0x000) holds CFG0_RESET. All other writable words read 0.
- R9: In the lock word (offset 0x00C), only bits [31:24] are writable; they form a mask. Bits [23:16] show the `loop_locked` inputs. Bit 0 is 1 exactly when every loop whose mask bit is 0 is locked. All other bits read 0.
- R10: `remap_o` always equals bit 0 of configuration word 0. `led_o[i]` always equals bit i of configuration word 1 (offset 0x004), which is a full 32-bit read/write word.
- R11: A read from an undefined offset returns 0, and a write to one has no effect. The switch word (0x008) reads 0. The identity words at 0xFF8 (REV_VALUE) and 0xFFC (ID_VALUE) ignore writes.
- R12: The return data word and the status word cannot be written from the bus. A bus write to either leaves its value unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe for the current address |
| addr | input | 12 | Byte address within the window (bits [1:0] ignored) |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Combinational read data for `addr` |
| loop_locked | input | 8 | Per-loop lock flags |
| remap_o | output | 1 | Remap control line |
| led_o | output | NUM_LEDS | LED drive lines |

## Verification
The bench builds the block with three setting entries, so NUM_OSC is not a power of two. This puts the device number 3 within reach: it fits the internal index width but names no entry, so the rejection on the full device number can be seen at the ports. A device number with upper bits set that alias entry 1 is also used. Four LED lines are used, with a configuration-word value whose upper bits differ from its low nibble. This shows that only the low bits reach the pins while the word itself keeps all 32 bits.

// File: rtl/bcc_pkg.sv
package bcc_pkg;

    localparam int DATA_W   = 32;
    localparam int ADDR_W   = 12;
    localparam int LOOPS    = 8;
    localparam int MAX_OSC  = 8;

    localparam logic [ADDR_W-1:0] OFF_CFG0   = 12'h000;
    localparam logic [ADDR_W-1:0] OFF_CFG1   = 12'h004;
    localparam logic [ADDR_W-1:0] OFF_SWITCH = 12'h008;
    localparam logic [ADDR_W-1:0] OFF_LOCK   = 12'h00C;
    localparam logic [ADDR_W-1:0] OFF_RTN    = 12'h0A0;
    localparam logic [ADDR_W-1:0] OFF_DOUT   = 12'h0A4;
    localparam logic [ADDR_W-1:0] OFF_CMD    = 12'h0A8;
    localparam logic [ADDR_W-1:0] OFF_STAT   = 12'h0AC;
    localparam logic [ADDR_W-1:0] OFF_REV    = 12'hFF8;
    localparam logic [ADDR_W-1:0] OFF_ID     = 12'hFFC;

    localparam logic [5:0]        FUNC_OSC   = 6'd1;
    localparam logic [DATA_W-1:0] CMD_RESET  = 32'h0010_0000;

    typedef struct packed {
        logic        start;
        logic        wr;
        logic [3:0]  rsv_hi;
        logic [5:0]  func;
        logic [7:0]  rsv_lo;
        logic [11:0] dev;
    } cmd_t;

    typedef struct packed {
        logic err;
        logic done;
    } stat_t;

    function automatic logic word_hit(logic [ADDR_W-1:0] a, logic [ADDR_W-1:0] off);
        return a[ADDR_W-1:2] == off[ADDR_W-1:2];
    endfunction

    function automatic cmd_t cmd_sanitize(logic [DATA_W-1:0] v);
        cmd_t c;
        c        = cmd_t'(v);
        c.start  = 1'b0;
        c.rsv_hi = '0;
        c.rsv_lo = '0;
        return c;
    endfunction

    function automatic logic req_ok(cmd_t c, int unsigned n);
        return (c.func == FUNC_OSC) && (32'(c.dev) < n);
    endfunction

    function automatic logic all_unmasked_locked(logic [LOOPS-1:0] locked,
                                                 logic [LOOPS-1:0] mask);
        return &(locked | mask);
    endfunction

endpackage

// File: rtl/bcc_osc_table.sv
module bcc_osc_table #(
    parameter int                  NUM_OSC   = 4,
    parameter logic [7:0][31:0]    OSC_RESET = '0,
    parameter int                  IDX_W     = (NUM_OSC > 1) ? $clog2(NUM_OSC) : 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             we,
    input  logic [IDX_W-1:0] widx,
    input  logic [31:0]      wdata,
    input  logic [IDX_W-1:0] ridx,
    output logic [31:0]      rdata
);

    logic [31:0] entry [NUM_OSC];

    for (genvar g = 0; g < NUM_OSC; g++) begin : g_entry
        always_ff @(posedge clk) begin
            if (rst) begin
                entry[g] <= OSC_RESET[g];
            end else if (we && (widx == IDX_W'(g))) begin
                entry[g] <= wdata;
            end
        end
    end

    always_comb begin
        rdata = '0;
        for (int i = 0; i < NUM_OSC; i++) begin
            if (ridx == IDX_W'(i)) rdata = entry[i];
        end
    end

endmodule

// File: rtl/bcc_cfg_channel.sv
module bcc_cfg_channel
    import bcc_pkg::*;
#(
    parameter int               NUM_OSC   = 4,
    parameter logic [7:0][31:0] OSC_RESET = '0
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        cmd_we,
    input  logic        dout_we,
    input  logic [31:0] wdata,
    output cmd_t        cmd_q,
    output stat_t       stat_q,
    output logic [31:0] rtn_q,
    output logic [31:0] dout_q
);

    localparam int IDX_W = (NUM_OSC > 1) ? $clog2(NUM_OSC) : 1;

    cmd_t        req;
    logic        ok;
    logic        go;
    logic [31:0] tbl_rd;

    assign req = cmd_t'(wdata);
    assign ok  = req_ok(req, NUM_OSC);
    assign go  = cmd_we && req.start;

    bcc_osc_table #(
        .NUM_OSC   (NUM_OSC),
        .OSC_RESET (OSC_RESET),
        .IDX_W     (IDX_W)
    ) u_table (
        .clk   (clk),
        .rst   (rst),
        .we    (go && ok && req.wr),
        .widx  (req.dev[IDX_W-1:0]),
        .wdata (dout_q),
        .ridx  (req.dev[IDX_W-1:0]),
        .rdata (tbl_rd)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            cmd_q  <= cmd_t'(CMD_RESET);
            stat_q <= '0;
            rtn_q  <= '0;
            dout_q <= '0;
        end else begin
            if (dout_we) dout_q <= wdata;
            if (cmd_we) begin
                cmd_q  <= cmd_sanitize(wdata);
                stat_q <= go ? '{err: ~ok, done: 1'b1} : '0;
                if (go && ok && !req.wr) rtn_q <= tbl_rd;
            end
        end
    end

endmodule

// File: rtl/bcc_lock_status.sv
module bcc_lock_status
    import bcc_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             mask_we,
    input  logic [LOOPS-1:0] mask_in,
    input  logic [LOOPS-1:0] locked,
    output logic [31:0]      value
);

    logic [LOOPS-1:0] mask_q;

    always_ff @(posedge clk) begin
        if (rst)          mask_q <= '0;
        else if (mask_we) mask_q <= mask_in;
    end

    assign value = {mask_q, locked, 15'b0, all_unmasked_locked(locked, mask_q)};

endmodule

// File: rtl/board_cfg_ctrl.sv
module board_cfg_ctrl
    import bcc_pkg::*;
#(
    parameter int               NUM_OSC    = 4,
    parameter logic [7:0][31:0] OSC_RESET  = {32'h0, 32'h0, 32'h0, 32'h0,
                                              32'h0200_0000, 32'h0180_0000,
                                              32'h0100_0000, 32'h0080_0000},
    parameter logic [31:0]      CFG0_RESET = 32'h0,
    parameter int               NUM_LEDS   = 8,
    parameter logic [31:0]      ID_VALUE   = 32'h4100_0010,
    parameter logic [31:0]      REV_VALUE  = 32'h0000_0001
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                wr_en,
    input  logic [11:0]         addr,
    input  logic [31:0]         wdata,
    output logic [31:0]         rdata,
    input  logic [7:0]          loop_locked,
    output logic                remap_o,
    output logic [NUM_LEDS-1:0] led_o
);

    logic [31:0] cfg0_q, cfg1_q;
    logic [31:0] lock_val;
    logic [31:0] cmd_val;
    logic [1:0]  stat_val;
    logic [31:0] rtn_val, dout_val;
    cmd_t        cmd_q;
    stat_t       stat_q;
    wire         unused_ok = &{1'b0, addr[1:0]};

    logic we_cfg0, we_cfg1, we_lock, we_dout, we_cmd;
    assign we_cfg0 = wr_en && word_hit(addr, OFF_CFG0);
    assign we_cfg1 = wr_en && word_hit(addr, OFF_CFG1);
    assign we_lock = wr_en && word_hit(addr, OFF_LOCK);
    assign we_dout = wr_en && word_hit(addr, OFF_DOUT);
    assign we_cmd  = wr_en && word_hit(addr, OFF_CMD);

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg0_q <= CFG0_RESET;
            cfg1_q <= '0;
        end else begin
            if (we_cfg0) cfg0_q <= wdata;
            if (we_cfg1) cfg1_q <= wdata;
        end
    end

    assign remap_o = cfg0_q[0];
    assign led_o   = cfg1_q[NUM_LEDS-1:0];

    bcc_cfg_channel #(
        .NUM_OSC   (NUM_OSC),
        .OSC_RESET (OSC_RESET)
    ) u_chan (
        .clk     (clk),
        .rst     (rst),
        .cmd_we  (we_cmd),
        .dout_we (we_dout),
        .wdata   (wdata),
        .cmd_q   (cmd_q),
        .stat_q  (stat_q),
        .rtn_q   (rtn_val),
        .dout_q  (dout_val)
    );

    assign cmd_val  = cmd_q;
    assign stat_val = stat_q;

    bcc_lock_status u_lock (
        .clk     (clk),
        .rst     (rst),
        .mask_we (we_lock),
        .mask_in (wdata[31:24]),
        .locked  (loop_locked),
        .value   (lock_val)
    );

    always_comb begin
        rdata = '0;
        if      (word_hit(addr, OFF_CFG0)) rdata = cfg0_q;
        else if (word_hit(addr, OFF_CFG1)) rdata = cfg1_q;
        else if (word_hit(addr, OFF_LOCK)) rdata = lock_val;
        else if (word_hit(addr, OFF_RTN))  rdata = rtn_val;
        else if (word_hit(addr, OFF_DOUT)) rdata = dout_val;
        else if (word_hit(addr, OFF_CMD))  rdata = cmd_val;
        else if (word_hit(addr, OFF_STAT)) rdata = {30'b0, stat_val};
        else if (word_hit(addr, OFF_REV))  rdata = REV_VALUE;
        else if (word_hit(addr, OFF_ID))   rdata = ID_VALUE;
    end

endmodule

module bcc_checker
    import bcc_pkg::*;
(
    input logic        clk,
    input logic        rst,
    input logic        wr_en,
    input logic [11:0] addr,
    input logic [31:0] wdata,
    input logic [31:0] cmd_val,
    input logic [1:0]  stat_val,
    input logic        remap_o
);

    wire unused_ok = &{1'b0, wdata[30:26], wdata[19:1]};

    logic cmd_wr;
    assign cmd_wr = wr_en && word_hit(addr, OFF_CMD);

    assert_cmd_reset_R8: assert property (@(posedge clk)
        rst |=> (cmd_val == CMD_RESET && stat_val == 2'b00));

    assert_cmd_clean_R2: assert property (@(posedge clk) disable iff (rst)
        cmd_wr |=> (cmd_val[31] == 1'b0 && cmd_val[29:26] == 4'b0 && cmd_val[19:12] == 8'b0));

    assert_status_clear_R3: assert property (@(posedge clk) disable iff (rst)
        (cmd_wr && !wdata[31]) |=> (stat_val == 2'b00));

    assert_done_set_R4: assert property (@(posedge clk) disable iff (rst)
        (cmd_wr && wdata[31]) |=> stat_val[0]);

    assert_bad_func_R5: assert property (@(posedge clk) disable iff (rst)
        (cmd_wr && wdata[31] && wdata[25:20] != FUNC_OSC) |=> (stat_val == 2'b11));

    assert_remap_follow_R10: assert property (@(posedge clk) disable iff (rst)
        (wr_en && word_hit(addr, OFF_CFG0)) |=> (remap_o == $past(wdata[0])));

endmodule

bind board_cfg_ctrl bcc_checker u_chk (
    .clk      (clk),
    .rst      (rst),
    .wr_en    (wr_en),
    .addr     (addr),
    .wdata    (wdata),
    .cmd_val  (cmd_val),
    .stat_val (stat_val),
    .remap_o  (remap_o)
);

// File: tb/tb_board_cfg_ctrl.sv
module tb_board_cfg_ctrl;

    localparam int          NOSC = 3;
    localparam int          NLED = 4;
    localparam logic [31:0] IDV  = 32'hB0A7_0001;
    localparam logic [31:0] REVV = 32'h0000_0042;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [11:0] addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic [7:0]  loop_locked = 8'hA5;
    logic        remap_o;
    logic [NLED-1:0] led_o;

    int checks = 0;
    int fails  = 0;
    bit ended  = 1'b0;

    always #5 clk = ~clk;

    board_cfg_ctrl #(
        .NUM_OSC    (NOSC),
        .OSC_RESET  ({32'h0, 32'h0, 32'h0, 32'h0, 32'h0,
                      32'h0000_3000, 32'h0000_2000, 32'h0000_1000}),
        .CFG0_RESET (32'h0000_0001),
        .NUM_LEDS   (NLED),
        .ID_VALUE   (IDV),
        .REV_VALUE  (REVV)
    ) dut (
        .clk         (clk),
        .rst         (rst),
        .wr_en       (wr_en),
        .addr        (addr),
        .wdata       (wdata),
        .rdata       (rdata),
        .loop_locked (loop_locked),
        .remap_o     (remap_o),
        .led_o       (led_o)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %08h expected %08h", tag, act, exp);
        end
    endtask

    task automatic bus_wr(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic bus_rd(input logic [11:0] a, output logic [31:0] d);
        @(negedge clk);
        addr = a;
        #1 d = rdata;
    endtask

    task automatic expect_rd(input string tag, input logic [11:0] a, input logic [31:0] exp);
        logic [31:0] d;
        bus_rd(a, d);
        check(tag, d, exp);
    endtask

    // read entry n through the channel: function 1, read direction
    task automatic chan_read(input string tag, input logic [11:0] dev, input logic [31:0] exp);
        bus_wr(12'h0A8, 32'h8010_0000 | 32'(dev));
        expect_rd({tag, " status"}, 12'h0AC, 32'h1);
        expect_rd(tag, 12'h0A0, exp);
    endtask

    task automatic t_reset;
        expect_rd("R8 cmd reset", 12'h0A8, 32'h0010_0000);
        expect_rd("R8 status reset", 12'h0AC, 32'h0);
        expect_rd("R8 cfg0 reset", 12'h000, 32'h1);
        expect_rd("R8 cfg1 reset", 12'h004, 32'h0);
        expect_rd("R8 rtn reset", 12'h0A0, 32'h0);
        expect_rd("R8 dout reset", 12'h0A4, 32'h0);
        check("R10 remap at reset", 32'(remap_o), 32'h1);
        check("R10 leds at reset", 32'(led_o), 32'h0);
        expect_rd("R11 id", 12'hFFC, IDV);
        expect_rd("R11 rev", 12'hFF8, REVV);
    endtask

    task automatic t_cmd_fields;
        bus_wr(12'h0A8, 32'hFFFF_FFFF);
        expect_rd("R2 sanitized cmd", 12'h0A8, 32'h43F0_0FFF);
        expect_rd("R5 func 3F rejected", 12'h0AC, 32'h3);
        bus_wr(12'h0A8, 32'h0010_0001);
        expect_rd("R3 write clears status", 12'h0AC, 32'h0);
        expect_rd("R1 cmd fields kept", 12'h0A8, 32'h0010_0001);
    endtask

    task automatic t_valid;
        chan_read("R7 read entry1 reset", 12'h001, 32'h0000_2000);
        chan_read("R7 read entry0 reset", 12'h000, 32'h0000_1000);
        bus_wr(12'h0A4, 32'hCAFE_0002);
        expect_rd("R6 dout readback", 12'h0A4, 32'hCAFE_0002);
        bus_wr(12'h0A8, 32'hC010_0002);
        expect_rd("R4 done after write", 12'h0AC, 32'h1);
        expect_rd("R1 write dir stored", 12'h0A8, 32'h4010_0002);
        chan_read("R6 entry2 written", 12'h002, 32'hCAFE_0002);
        chan_read("R6 entry1 untouched", 12'h001, 32'h0000_2000);
    endtask

    task automatic t_reject;
        bus_wr(12'h0A4, 32'hDEAD_BEEF);
        bus_wr(12'h0A8, 32'hC010_0003);
        expect_rd("R5 dev==NUM_OSC write", 12'h0AC, 32'h3);
        bus_wr(12'h0A8, 32'hC010_0101);
        expect_rd("R5 dev aliasing write", 12'h0AC, 32'h3);
        chan_read("R5 entry1 kept", 12'h001, 32'h0000_2000);
        bus_wr(12'h0A8, 32'h8020_0000);
        expect_rd("R5 func 2 read status", 12'h0AC, 32'h3);
        expect_rd("R5 rtn unchanged", 12'h0A0, 32'h0000_2000);
        bus_wr(12'h0A8, 32'h8010_0003);
        expect_rd("R5 dev==NUM_OSC read", 12'h0AC, 32'h3);
        expect_rd("R5 rtn unchanged 2", 12'h0A0, 32'h0000_2000);
        chan_read("R5 entry2 kept", 12'h002, 32'hCAFE_0002);
        chan_read("R5 entry0 kept", 12'h000, 32'h0000_1000);
    endtask

    task automatic t_lock;
        expect_rd("R9 lock mask 0", 12'h00C, 32'h00A5_0000);
        bus_wr(12'h00C, 32'hFFFF_FFFF);
        expect_rd("R9 full mask", 12'h00C, 32'hFFA5_0001);
        bus_wr(12'h00C, 32'h5A00_0000);
        expect_rd("R9 mask covers unlocked", 12'h00C, 32'h5AA5_0001);
        bus_wr(12'h00C, 32'h58FF_FFFF);
        expect_rd("R9 loop1 unmasked", 12'h00C, 32'h58A5_0000);
        @(negedge clk);
        loop_locked = 8'hFF;
        expect_rd("R9 all locked", 12'h00C, 32'h58FF_0001);
    endtask

    task automatic t_side;
        bus_wr(12'h000, 32'h0000_0000);
        #1 check("R10 remap low", 32'(remap_o), 32'h0);
        bus_wr(12'h000, 32'h8000_0003);
        #1 check("R10 remap high", 32'(remap_o), 32'h1);
        bus_wr(12'h004, 32'hFFFF_FFF5);
        #1 check("R10 leds", 32'(led_o), 32'h5);
        expect_rd("R10 cfg1 full word", 12'h004, 32'hFFFF_FFF5);
    endtask

    task automatic t_ignored;
        bus_wr(12'h500, 32'h1234_5678);
        expect_rd("R11 undefined reads 0", 12'h500, 32'h0);
        bus_wr(12'h008, 32'hFFFF_FFFF);
        expect_rd("R11 switch reads 0", 12'h008, 32'h0);
        bus_wr(12'hFFC, 32'h0);
        expect_rd("R11 id write ignored", 12'hFFC, IDV);
        expect_rd("R11 cfg0 untouched", 12'h000, 32'h8000_0003);
        bus_wr(12'h0A0, 32'h5555_5555);
        expect_rd("R12 rtn not writable", 12'h0A0, 32'h0000_1000);
        bus_wr(12'h0A8, 32'h8030_0000);
        bus_wr(12'h0AC, 32'h0);
        expect_rd("R12 status not writable", 12'h0AC, 32'h3);
    endtask

    task automatic finish_run;
        if (!ended) begin
            ended = 1'b1;
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_cmd_fields();
        t_valid();
        t_reject();
        t_lock();
        t_side();
        t_ignored();
        finish_run();
    end

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

endmodule